// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a legacy-style I/O controller. It sits on a byte-wide I/O bus with separate write and read strobes and answers at two addresses: an index port and the data port directly above it. A strap input chooses between the primary pair 0x4E/0x4F and the alternate pair 0x2E/0x2F. After reset the block is locked, and configuration traffic has no effect until software writes the unlock key twice in succession to the index port.

Once it is open, software writes a register number to the index port and then reads or writes that register through the data port. One register selects a logical device. Three further registers reach that device's enable bit and the two bytes of its 16-bit I/O base. Every device's enable and base are driven out continuously for downstream address decoders. A single lock byte written to the index port closes the block again. The usual sequence is: unlock, select the device, clear its enable, program the base, set the enable, lock.

The key handling is a three-state machine. ST_LOCKED moves to ST_KEY_HALF on an index write of 0xA5. ST_KEY_HALF moves to ST_OPEN on a second index write of 0xA5 and falls back to ST_LOCKED on any other index write. ST_OPEN returns to ST_LOCKED on an index write of 0xAA; every other index write there stores the byte as the current register number.

Top module: `sio_keyport`

## Requirements
- R1: The block opens only after two index-port writes of 0xA5 with no other index-port write between them. Reads and data-port accesses between the two key writes do not disturb the sequence.
- R2: After one 0xA5, an index-port write of any other byte discards the partial key, so two fresh 0xA5 writes are needed.
- R3: While open, an index-port write of 0xAA locks the block again.
- R4: With strap_alt low the index/data ports are 0x4E/0x4F. With strap_alt high they are 0x2E/0x2F. Accesses to the unselected pair, or to any other address, have no effect.
- R5: While open, an index-port write of a byte other than 0xAA sets the current register number, and index-port reads return it. Data-port accesses then reach that register.
- R6: While locked, including after a single key byte, data-port writes are ignored and reads of either port return 0xFF.
- R7: Register 0x07 holds the logical device number, 8 bits, readable. For the selected device, register 0x30 bit 0 is the enable (other bits read 0), 0x60 is base bits 15:8 and 0x61 is base bits 7:0. Device d drives dev_en[d] and dev_base[16*d+15:16*d]. There are NDEV devices (default 4).
- R8: Reads of any other register number return 0x00 and writes to them are ignored. When the device number is NDEV or above, registers 0x30/0x60/0x61 read 0x00 and ignore writes.
- R9: Reset leaves the block locked with register number 0, device number 0, all enables 0, all bases 0 and io_rdata 0x00.
- R10: io_rdata is loaded on the clock edge that samples a read strobe at either selected port and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Selects the alternate port pair 0x2E/0x2F |
| io_addr | input | ADDR_W (16) | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_en | output | NDEV (4) | Per-device enable |
| dev_base | output | 16*NDEV (64) | Per-device 16-bit I/O base |

## Verification
The bench targets the key sequence itself. A single 0xA5, a key broken by a stray index byte, and a key with a data-port access in the middle each have a correct outcome. A design that counts key bytes instead of matching consecutive ones would open too early, and one that does not reset on a stray byte would open after three writes with junk between them. It also targets the port strap, where a decoder that ignores the strap would react to the wrong pair. Finally it covers out-of-range device numbers and unmapped registers, where a design that truncates the device number would alias device 5 onto device 1 and corrupt its base. Random traffic with a bias toward the key bytes drives the block in and out of the open state many times. Every read and every output is compared against a bench model.

// File: rtl/sio_keyport_pkg.sv
`timescale 1ns/1ps
package sio_keyport_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_ENTER   = 8'hA5;
    localparam logic [7:0] KEY_LEAVE   = 8'hAA;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ENA     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] READ_LOCKED = 8'hFF;

    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } bus_hit_t;

endpackage

// File: rtl/sio_port_decode.sv
`timescale 1ns/1ps
module sio_port_decode
    import sio_keyport_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] PRI_IDX = 16'h004E,
    parameter logic [15:0] ALT_IDX = 16'h002E
) (
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output bus_hit_t          hit
);
    localparam logic [ADDR_W-1:0] PRI_I = ADDR_W'(PRI_IDX);
    localparam logic [ADDR_W-1:0] ALT_I = ADDR_W'(ALT_IDX);

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;
    logic              at_idx;
    logic              at_dat;

    always_comb begin
        idx_addr   = strap_alt ? ALT_I : PRI_I;
        dat_addr   = idx_addr + ADDR_W'(1);
        at_idx     = (io_addr == idx_addr);
        at_dat     = (io_addr == dat_addr);
        hit.idx_wr = at_idx & io_wr;
        hit.idx_rd = at_idx & io_rd;
        hit.dat_wr = at_dat & io_wr;
        hit.dat_rd = at_dat & io_rd;
    end
endmodule

// File: rtl/sio_key_fsm.sv
`timescale 1ns/1ps
module sio_key_fsm
    import sio_keyport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open
);
    key_state_t state_q;
    key_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_ENTER) state_d = ST_KEY_HALF;
            end
            ST_KEY_HALF: begin
                if (idx_wr) state_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
            end
            ST_OPEN: begin
                cfg_open = 1'b1;
                if (idx_wr && wdata == KEY_LEAVE) state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end
endmodule

// File: rtl/sio_reg_bank.sv
`timescale 1ns/1ps
module sio_reg_bank
    import sio_keyport_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_open,
    input  bus_hit_t             hit,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic [NDEV-1:0]      dev_en,
    output logic [NDEV*16-1:0]   dev_base
);
    localparam int BASE_W = 16;

    logic [7:0]        index_q;
    logic [7:0]        ldn_q;
    logic [7:0]        rdata_q;
    logic [7:0]        reg_val;
    logic              cfg_wr;
    logic              ldn_ok;
    logic              en_sel;
    logic [BASE_W-1:0] base_sel;

    assign cfg_wr = cfg_open & hit.dat_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else begin
            if (cfg_open && hit.idx_wr && wdata != KEY_LEAVE) index_q <= wdata;
            if (cfg_wr && index_q == IDX_LDN) ldn_q <= wdata;
        end
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        logic              en_q;
        logic [BASE_W-1:0] base_q;
        logic              sel;

        assign sel = (ldn_q == 8'(d));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                base_q <= '0;
            end else if (cfg_wr && sel) begin
                if (index_q == IDX_ENA)     en_q         <= wdata[0];
                if (index_q == IDX_BASE_HI) base_q[15:8] <= wdata;
                if (index_q == IDX_BASE_LO) base_q[7:0]  <= wdata;
            end
        end

        assign dev_en[d]                     = en_q;
        assign dev_base[d*BASE_W +: BASE_W]  = base_q;
    end

    always_comb begin
        ldn_ok   = 1'b0;
        en_sel   = 1'b0;
        base_sel = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (ldn_q == 8'(d)) begin
                ldn_ok   = 1'b1;
                en_sel   = dev_en[d];
                base_sel = dev_base[d*BASE_W +: BASE_W];
            end
        end
        reg_val = 8'h00;
        case (index_q)
            IDX_LDN:     reg_val = ldn_q;
            IDX_ENA:     reg_val = ldn_ok ? {7'b0, en_sel} : 8'h00;
            IDX_BASE_HI: reg_val = ldn_ok ? base_sel[15:8] : 8'h00;
            IDX_BASE_LO: reg_val = ldn_ok ? base_sel[7:0]  : 8'h00;
            default:     reg_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else if (hit.idx_rd) begin
            rdata_q <= cfg_open ? index_q : READ_LOCKED;
        end else if (hit.dat_rd) begin
            rdata_q <= cfg_open ? reg_val : READ_LOCKED;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sio_keyport.sv
`timescale 1ns/1ps
module sio_keyport
    import sio_keyport_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          NDEV    = 4,
    parameter logic [15:0] PRI_IDX = 16'h004E,
    parameter logic [15:0] ALT_IDX = 16'h002E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_alt,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic [NDEV-1:0]    dev_en,
    output logic [NDEV*16-1:0] dev_base
);
    bus_hit_t hit;
    logic     cfg_open;

    sio_port_decode #(
        .ADDR_W (ADDR_W),
        .PRI_IDX(PRI_IDX),
        .ALT_IDX(ALT_IDX)
    ) u_decode (
        .strap_alt(strap_alt),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .hit      (hit)
    );

    sio_key_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (hit.idx_wr),
        .wdata   (io_wdata),
        .cfg_open(cfg_open)
    );

    sio_reg_bank #(
        .NDEV(NDEV)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_open(cfg_open),
        .hit     (hit),
        .wdata   (io_wdata),
        .rdata   (io_rdata),
        .dev_en  (dev_en),
        .dev_base(dev_base)
    );
endmodule

// File: rtl/sio_keyport_chk.sv
`timescale 1ns/1ps
module sio_keyport_chk #(
    parameter int          ADDR_W  = 16,
    parameter int          NDEV    = 4,
    parameter logic [15:0] PRI_IDX = 16'h004E,
    parameter logic [15:0] ALT_IDX = 16'h002E
) (
    input logic               clk,
    input logic               rst_n,
    input logic               strap_alt,
    input logic [ADDR_W-1:0]  io_addr,
    input logic               io_wr,
    input logic               io_rd,
    input logic [7:0]         io_wdata,
    input logic [7:0]         io_rdata,
    input logic [NDEV-1:0]    dev_en,
    input logic [NDEV*16-1:0] dev_base,
    input logic               cfg_open
);
    logic [ADDR_W-1:0] ci;
    logic              c_idx;
    logic              c_dat;

    assign ci    = strap_alt ? ADDR_W'(ALT_IDX) : ADDR_W'(PRI_IDX);
    assign c_idx = (io_addr == ci);
    assign c_dat = (io_addr == ci + ADDR_W'(1));

    AST_ENTER_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(c_idx && io_wr && io_wdata == 8'hA5)); // R1

    AST_EXIT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && c_idx && io_wr && io_wdata == 8'hAA) |=> !cfg_open); // R3

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && (c_idx || c_dat)) |=> io_rdata == 8'hFF); // R6

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(dev_en) && $stable(dev_base))); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && (c_idx || c_dat)) |=> $stable(io_rdata)); // R10
endmodule

bind sio_keyport sio_keyport_chk #(
    .ADDR_W (ADDR_W),
    .NDEV   (NDEV),
    .PRI_IDX(PRI_IDX),
    .ALT_IDX(ALT_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_alt(strap_alt),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .dev_en   (dev_en),
    .dev_base (dev_base),
    .cfg_open (cfg_open)
);

// File: tb/sio_keyport_bench.sv
`timescale 1ns/1ps
module sio_keyport_bench;
    localparam int NDEV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap_alt = 1'b0;
    logic [15:0]       io_addr = 16'h0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = 8'h0;
    logic [7:0]        io_rdata;
    logic [NDEV-1:0]   dev_en;
    logic [NDEV*16-1:0] dev_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    bit          m_open, m_half;
    logic [7:0]  m_idx, m_ldn, m_rdata;
    logic [NDEV-1:0] m_en;
    logic [15:0] m_base [NDEV];

    always #4 clk = ~clk;

    sio_keyport u_sio_keyport (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_en(dev_en), .dev_base(dev_base)
    );

    function automatic logic [15:0] idx_port();
        return strap_alt ? 16'h002E : 16'h004E;
    endfunction

    function automatic logic [7:0] reg_value();
        bit ok = (m_ldn < NDEV);
        case (m_idx)
            8'h07: return m_ldn;
            8'h30: return ok ? {7'b0, m_en[m_ldn[1:0]]} : 8'h00;
            8'h60: return ok ? m_base[m_ldn[1:0]][15:8] : 8'h00;
            8'h61: return ok ? m_base[m_ldn[1:0]][7:0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        if (a == idx_port())              return m_open ? m_idx : 8'hFF;
        if (a == idx_port() + 16'd1)      return m_open ? reg_value() : 8'hFF;
        return m_rdata;
    endfunction

    task automatic model_reset();
        m_open = 0; m_half = 0; m_idx = 0; m_ldn = 0; m_rdata = 0; m_en = '0;
        for (int d = 0; d < NDEV; d++) m_base[d] = 16'h0;
    endtask

    task automatic model_write(logic [15:0] a, logic [7:0] v);
        bit ok = (m_ldn < NDEV);
        if (a == idx_port()) begin
            if (m_open) begin
                if (v == 8'hAA) m_open = 0; else m_idx = v;
            end else if (m_half) begin
                m_half = 0;
                if (v == 8'hA5) m_open = 1;
            end else if (v == 8'hA5) m_half = 1;
        end else if (a == idx_port() + 16'd1 && m_open) begin
            case (m_idx)
                8'h07: m_ldn = v;
                8'h30: if (ok) m_en[m_ldn[1:0]] = v[0];
                8'h60: if (ok) m_base[m_ldn[1:0]][15:8] = v;
                8'h61: if (ok) m_base[m_ldn[1:0]][7:0] = v;
                default: ;
            endcase
        end
    endtask

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic check_outputs(string req);
        logic [NDEV*16-1:0] eb;
        for (int d = 0; d < NDEV; d++) eb[d*16 +: 16] = m_base[d];
        check({req, " dev_en"}, 64'(dev_en), 64'(m_en));
        check({req, " dev_base"}, 64'(dev_base), 64'(eb));
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_wdata = v; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic io_read(logic [15:0] a, string req);
        logic [7:0] e;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        io_rd = 1'b0;
        m_rdata = e;
        check(req, 64'(io_rdata), 64'(e));
    endtask

    task automatic do_reset(bit alt);
        @(negedge clk);
        rst_n = 1'b0; strap_alt = alt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic unlock();
        io_write(idx_port(), 8'hA5);
        io_write(idx_port(), 8'hA5);
    endtask

    task automatic set_reg(logic [7:0] r, logic [7:0] v);
        io_write(idx_port(), r);
        io_write(idx_port() + 16'd1, v);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] p;
        void'($urandom(32'h5107_C0DE));
        do_reset(1'b0);
        // R9: reset state
        check("R9 rdata", 64'(io_rdata), 64'h00);
        check("R9 dev_en", 64'(dev_en), 64'h0);
        check("R9 dev_base", 64'(dev_base), 64'h0);
        // R6: locked accesses
        io_write(16'h004F, 8'h01);
        check_outputs("R6 locked write");
        io_read(16'h004F, "R6 locked data read");
        io_read(16'h004E, "R6 locked index read");
        // R1: one key byte is not enough
        io_write(16'h004E, 8'hA5);
        io_read(16'h004F, "R1 half key");
        io_write(16'h004F, 8'h33); // data access between keys
        io_write(16'h004E, 8'hA5);
        io_read(16'h004E, "R1 open index read");
        check("R1 open", 64'(m_open), 64'h1);
        io_write(16'h004E, 8'hAA);
        // R2: broken key
        io_write(16'h004E, 8'hA5);
        io_write(16'h004E, 8'h12);
        io_write(16'h004E, 8'hA5);
        io_read(16'h004F, "R2 broken key still locked");
        io_write(16'h004E, 8'hA5);
        io_read(16'h004E, "R2 reopened");
        // R5 / R7: program device 2
        set_reg(8'h07, 8'h02);
        io_read(16'h004F, "R7 ldn readback");
        set_reg(8'h30, 8'h00);
        set_reg(8'h60, 8'h03);
        set_reg(8'h61, 8'hF8);
        set_reg(8'h30, 8'hFF);
        io_read(16'h004F, "R7 enable bit0 only");
        io_read(16'h004E, "R5 index readback");
        check("R7 dev_en[2]", 64'(dev_en), 64'h4);
        check("R7 dev_base[2]", 64'(dev_base[47:32]), 64'h03F8);
        // R8: unmapped index and out-of-range device
        set_reg(8'h22, 8'h55);
        io_read(16'h004F, "R8 unmapped reads 0");
        set_reg(8'h07, 8'h05);
        set_reg(8'h60, 8'h77);
        set_reg(8'h30, 8'h01);
        io_read(16'h004F, "R8 ldn out of range");
        check_outputs("R8 no alias");
        // R3: exit key
        io_write(16'h004E, 8'hAA);
        io_read(16'h004F, "R3 locked after exit");
        // R4: alternate pair
        do_reset(1'b1);
        io_write(16'h004E, 8'hA5);
        io_write(16'h004E, 8'hA5);
        io_read(16'h002E, "R4 primary pair ignored");
        unlock();
        io_read(16'h002E, "R4 alternate open");
        set_reg(8'h61, 8'h9C);
        io_write(16'h004F, 8'h11);
        check_outputs("R4 alternate write");
        // random traffic, both straps
        for (int ph = 0; ph < 2; ph++) begin
            do_reset(ph[0]);
            for (int n = 0; n < 3000; n++) begin
                int sel = $urandom_range(0, 9);
                logic [7:0] v;
                case ($urandom_range(0, 9))
                    0, 1, 2: v = 8'hA5;
                    3:       v = 8'hAA;
                    4:       v = 8'h07;
                    5:       v = 8'h30;
                    6:       v = 8'h60;
                    7:       v = 8'h61;
                    8:       v = 8'($urandom_range(0, 5));
                    default: v = 8'($urandom);
                endcase
                if (sel < 4)      p = idx_port();
                else if (sel < 8) p = idx_port() + 16'd1;
                else if (sel == 8) p = strap_alt ? 16'h004E : 16'h002E;
                else              p = 16'($urandom);
                if ($urandom_range(0, 2) == 0) io_read(p, "R5 random read");
                else io_write(p, v);
                if (n % 16 == 0) check_outputs("R7 random outputs");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule